// File: doc/BRIEF.md
# Clock Generator Control Unit

This block is the digital control logic for a high-frequency clock generator that runs from a 32.768 kHz reference. Software stages new multiplier values (a 5-bit N and a 14-bit M) in a staging buffer through three byte-wide registers. The values are sent to the analog multiplier only when software writes a start command. The start command also selects a normal or a fast settling mode. The multiplier reports completion on a ready input. At that point a sticky done flag is set and an interrupt is raised.

The block generates two clock-enable streams in the multiplier clock domain:

- The core enable comes from a programmable pre-scaler with divisors 1 to 5. It is gated by the power-management enable. A divisor change takes effect only when a divided period ends.
- The host enable is a fixed divide-by-2. It is switched on by a rising edge of the host configuration enable, which also starts a clock-monitor interval.

Dropping the host enable, and a watchdog or debug reset, both return the multiplier and the pre-scaler to hardwired low-frequency defaults.

Top module: `clkgen_ctl`

## Requirements
- R1: Writes to address 0 (M bits 7:0), address 1 (M bits 13:8) and address 2 (N bits 4:0) are stored in the staging buffer and read back at the same addresses. They leave `mult_n` and `mult_m` unchanged.
- R2: A write to address 3 with bit 0 set, while not busy, starts an apply. On the next clock:
  - `mult_n`/`mult_m` take the buffer values;
  - `mult_fast` takes bit 1 of that write;
  - `mult_load` is high for exactly one cycle;
  - status bit 0 (busy, address 5) is 1.
- R3: An accepted apply sets the pending core divisor to 1. `core_div` reaches 1 within five cycles.
- R4: While busy, a cycle with `mult_ready` high clears busy and sets done (status bit 1). Done is sticky and `irq` equals done. Writing address 5 with bit 1 set clears done.
- R5: A start command written while busy is ignored. Buffer writes made while busy are kept and are applied by the next accepted start.
- R6: The divisor register (address 4, bits 2:0) accepts only whole-byte values 1 to 5. Other values, and any write while busy, leave it unchanged.
- R7: The pre-scaler adopts a new divisor only at the end of a divided period. While `pmc_en` is 1, `core_ce` pulses exactly once every `core_div` cycles. While `pmc_en` is 0, `core_ce` stays 0.
- R8: The host is enabled by a rising edge of `host_cfg_en`. It is disabled by a falling edge or by a soft reset. While enabled, `host_ce` is high on every second cycle.
- R9: Power-on reset and a soft reset (`wdt_rst` or `dbg_rst`) apply the defaults at once:
  - `mult_n`=0, `mult_m`=121, `core_div`=5;
  - host disabled and done cleared.
  A soft reset additionally starts an apply, with a `mult_load` pulse and busy set.
- R10: A falling edge of `host_cfg_en` while the host is enabled does the following:
  - loads the default N/M with a `mult_load` pulse and busy set;
  - sets the pending divisor to 5.
- R11: A host enable starts a monitor interval. Status bit 2 is 1 for 16 cycles, after which status bit 3 (monitor good) is 1. Disabling the host clears both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplier-domain clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_rst | input | 1 | Synchronous watchdog reset request |
| dbg_rst | input | 1 | Synchronous debug-interface reset request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| pmc_en | input | 1 | Power-management core clock enable |
| host_cfg_en | input | 1 | Host configuration clock enable |
| mult_ready | input | 1 | Multiplier has settled on the new setting |
| mult_n | output | 5 | Current N applied to the multiplier |
| mult_m | output | 14 | Current M applied to the multiplier |
| mult_fast | output | 1 | Fast settling mode for the current setting |
| mult_load | output | 1 | One-cycle pulse: load current setting |
| core_div | output | 3 | Divisor in effect in the core pre-scaler |
| core_ce | output | 1 | Core clock enable pulse |
| host_ce | output | 1 | Host clock enable pulse (divide by 2) |
| irq | output | 1 | Setting-change-complete interrupt |

## Verification
A corrupted current setting appears on `mult_n`/`mult_m` in the cycle after the offending edge. The checks compare these outputs with the staging buffer after every apply, and after every buffer write made during busy. A wrong divisor or counter in the pre-scaler shows up within one divided period as a wrong count of `core_ce` pulses over a 60-cycle window, which is a common multiple of all legal divisors. A stuck busy or done flag appears on `irq` and on the status register in the cycle after `mult_ready`. A host-enable state error appears within two cycles on `host_ce`.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    localparam int NW = 5;
    localparam int MW = 14;
    localparam int DW = 3;
    localparam int AW = 3;
    localparam int BW = 8;

    localparam logic [AW-1:0] A_MLO  = 3'd0;
    localparam logic [AW-1:0] A_MHI  = 3'd1;
    localparam logic [AW-1:0] A_NSET = 3'd2;
    localparam logic [AW-1:0] A_CTRL = 3'd3;
    localparam logic [AW-1:0] A_DIV  = 3'd4;
    localparam logic [AW-1:0] A_STAT = 3'd5;

    localparam logic [DW-1:0] DIV_MIN = 3'd1;
    localparam logic [DW-1:0] DIV_MAX = 3'd5;

    typedef struct packed {
        logic [NW-1:0] n;
        logic [MW-1:0] m;
    } mult_cfg_t;
endpackage

// File: rtl/clkgen_stage.sv
module clkgen_stage
    import clkgen_pkg::*;
#(
    parameter logic [NW-1:0] DEF_N = 5'd0,
    parameter logic [MW-1:0] DEF_M = 14'd121
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    input  logic          busy,
    output mult_cfg_t     staged,
    output logic          start_req,
    output logic          start_fast,
    output logic          div_wr,
    output logic [DW-1:0] div_val,
    output logic          done_clr
);
    mult_cfg_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (soft_rst) begin
            stg_d.n = DEF_N;
            stg_d.m = DEF_M;
        end else if (wr) begin
            case (addr)
                A_MLO:   stg_d.m[7:0]    = wdata;
                A_MHI:   stg_d.m[MW-1:8] = wdata[MW-9:0];
                A_NSET:  stg_d.n         = wdata[NW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q.n <= DEF_N;
            stg_q.m <= DEF_M;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign staged     = stg_q;
    assign start_req  = wr && (addr == A_CTRL) && wdata[0];
    assign start_fast = wdata[1];
    assign div_val    = wdata[DW-1:0];
    assign div_wr     = wr && (addr == A_DIV) && !busy
                        && (wdata[BW-1:DW] == '0)
                        && (div_val >= DIV_MIN) && (div_val <= DIV_MAX);
    assign done_clr   = wr && (addr == A_STAT) && wdata[1];
endmodule

// File: rtl/clkgen_presc.sv
module clkgen_presc
    import clkgen_pkg::*;
#(
    parameter logic [DW-1:0] DEF_DIV = 3'd5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          fallback,
    input  logic          force_one,
    input  logic          wr,
    input  logic [DW-1:0] wval,
    input  logic          pmc_en,
    output logic          tick,
    output logic          core_ce,
    output logic [DW-1:0] div_cur,
    output logic [DW-1:0] div_pend
);
    typedef struct packed {
        logic [DW-1:0] cur;
        logic [DW-1:0] pend;
        logic [DW-1:0] cnt;
    } presc_t;

    presc_t ps_d, ps_q;

    assign tick = (ps_q.cnt == ps_q.cur - 1'b1);

    always_comb begin
        ps_d = ps_q;
        if (soft_rst) begin
            ps_d.cur  = DEF_DIV;
            ps_d.pend = DEF_DIV;
            ps_d.cnt  = '0;
        end else begin
            if (fallback)       ps_d.pend = DEF_DIV;
            else if (force_one) ps_d.pend = DIV_MIN;
            else if (wr)        ps_d.pend = wval;
            if (tick) begin
                ps_d.cur = ps_q.pend;
                ps_d.cnt = '0;
            end else begin
                ps_d.cnt = ps_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q.cur  <= DEF_DIV;
            ps_q.pend <= DEF_DIV;
            ps_q.cnt  <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign core_ce  = tick && pmc_en;
    assign div_cur  = ps_q.cur;
    assign div_pend = ps_q.pend;
endmodule

// File: rtl/clkgen_host.sv
module clkgen_host #(
    parameter int MON_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic host_cfg_en,
    output logic host_ce,
    output logic host_drop,
    output logic mon_busy,
    output logic mon_ok
);
    localparam int CW = $clog2(MON_CYC + 1);
    localparam logic [CW-1:0] MON_LAST = CW'(MON_CYC - 1);

    typedef struct packed {
        logic          prev;
        logic          on;
        logic          ph;
        logic          mbusy;
        logic          mok;
        logic [CW-1:0] mcnt;
    } host_t;

    host_t hs_d, hs_q;
    logic  rise, fall;

    assign rise = host_cfg_en && !hs_q.prev;
    assign fall = !host_cfg_en && hs_q.prev;

    always_comb begin
        hs_d = hs_q;
        if (soft_rst) begin
            hs_d.prev  = host_cfg_en;
            hs_d.on    = 1'b0;
            hs_d.ph    = 1'b0;
            hs_d.mbusy = 1'b0;
            hs_d.mok   = 1'b0;
            hs_d.mcnt  = '0;
        end else begin
            hs_d.prev = host_cfg_en;
            if (hs_q.on) hs_d.ph = ~hs_q.ph;
            if (hs_q.mbusy) begin
                if (hs_q.mcnt == '0) begin
                    hs_d.mbusy = 1'b0;
                    hs_d.mok   = 1'b1;
                end else begin
                    hs_d.mcnt = hs_q.mcnt - 1'b1;
                end
            end
            if (rise) begin
                hs_d.on    = 1'b1;
                hs_d.ph    = 1'b0;
                hs_d.mbusy = 1'b1;
                hs_d.mok   = 1'b0;
                hs_d.mcnt  = MON_LAST;
            end else if (fall) begin
                hs_d.on    = 1'b0;
                hs_d.ph    = 1'b0;
                hs_d.mbusy = 1'b0;
                hs_d.mok   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign host_ce   = hs_q.on && hs_q.ph;
    assign host_drop = fall && hs_q.on && !soft_rst;
    assign mon_busy  = hs_q.mbusy;
    assign mon_ok    = hs_q.mok;
endmodule

// File: rtl/clkgen_ctl.sv
module clkgen_ctl
    import clkgen_pkg::*;
#(
    parameter logic [NW-1:0] DEF_N   = 5'd0,
    parameter logic [MW-1:0] DEF_M   = 14'd121,
    parameter logic [DW-1:0] DEF_DIV = 3'd5,
    parameter int            MON_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wdt_rst,
    input  logic          dbg_rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          pmc_en,
    input  logic          host_cfg_en,
    input  logic          mult_ready,
    output logic [NW-1:0] mult_n,
    output logic [MW-1:0] mult_m,
    output logic          mult_fast,
    output logic          mult_load,
    output logic [DW-1:0] core_div,
    output logic          core_ce,
    output logic          host_ce,
    output logic          irq
);
    typedef struct packed {
        mult_cfg_t cur;
        logic      fast;
        logic      busy;
        logic      done;
        logic      load;
    } ctl_t;

    ctl_t          st_d, st_q;
    mult_cfg_t     staged;
    logic          soft_rst, start_req, start_fast, div_wr, done_clr;
    logic          start_ok, host_drop, mon_busy, mon_ok, div_tick, busy;
    logic [DW-1:0] div_val, div_pend;

    assign soft_rst = wdt_rst || dbg_rst;
    assign busy     = st_q.busy;
    assign start_ok = start_req && !st_q.busy && !soft_rst && !host_drop;

    clkgen_stage #(.DEF_N(DEF_N), .DEF_M(DEF_M)) stage_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .busy(st_q.busy),
        .staged(staged), .start_req(start_req), .start_fast(start_fast),
        .div_wr(div_wr), .div_val(div_val), .done_clr(done_clr)
    );

    clkgen_presc #(.DEF_DIV(DEF_DIV)) presc_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .fallback(host_drop), .force_one(start_ok),
        .wr(div_wr), .wval(div_val), .pmc_en(pmc_en),
        .tick(div_tick), .core_ce(core_ce),
        .div_cur(core_div), .div_pend(div_pend)
    );

    clkgen_host #(.MON_CYC(MON_CYC)) host_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .host_cfg_en(host_cfg_en), .host_ce(host_ce),
        .host_drop(host_drop), .mon_busy(mon_busy), .mon_ok(mon_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (done_clr) st_d.done = 1'b0;
        if (st_q.busy && mult_ready) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
        if (soft_rst) begin
            st_d.cur.n = DEF_N;
            st_d.cur.m = DEF_M;
            st_d.fast  = 1'b0;
            st_d.busy  = 1'b1;
            st_d.load  = 1'b1;
            st_d.done  = 1'b0;
        end else if (host_drop) begin
            st_d.cur.n = DEF_N;
            st_d.cur.m = DEF_M;
            st_d.fast  = 1'b0;
            st_d.busy  = 1'b1;
            st_d.load  = 1'b1;
        end else if (start_ok) begin
            st_d.cur  = staged;
            st_d.fast = start_fast;
            st_d.busy = 1'b1;
            st_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur.n <= DEF_N;
            st_q.cur.m <= DEF_M;
            st_q.fast  <= 1'b0;
            st_q.busy  <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.load  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_MLO:   bus_rdata = staged.m[7:0];
            A_MHI:   bus_rdata = {{(BW - (MW - 8)){1'b0}}, staged.m[MW-1:8]};
            A_NSET:  bus_rdata = {{(BW - NW){1'b0}}, staged.n};
            A_CTRL:  bus_rdata = {{(BW - 2){1'b0}}, st_q.fast, 1'b0};
            A_DIV:   bus_rdata = {{(BW - DW){1'b0}}, div_pend};
            A_STAT:  bus_rdata = {{(BW - 4){1'b0}}, mon_ok, mon_busy, st_q.done, st_q.busy};
            default: bus_rdata = '0;
        endcase
    end

    assign mult_n    = st_q.cur.n;
    assign mult_m    = st_q.cur.m;
    assign mult_fast = st_q.fast;
    assign mult_load = st_q.load;
    assign irq       = st_q.done;
endmodule

// File: rtl/clkgen_ctl_chk.sv
module clkgen_ctl_chk
    import clkgen_pkg::*;
#(
    parameter logic [NW-1:0] DEF_N = 5'd0,
    parameter logic [MW-1:0] DEF_M = 14'd121
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          host_drop,
    input logic          busy,
    input logic          mult_ready,
    input logic          mult_load,
    input logic [NW-1:0] mult_n,
    input logic [MW-1:0] mult_m,
    input logic [DW-1:0] core_div,
    input logic          div_tick,
    input logic          core_ce,
    input logic          pmc_en,
    input logic          host_ce,
    input logic          irq
);
    AST_READY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mult_ready && !soft_rst && !host_drop |=> !busy && irq); // R4

    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mult_load |-> busy); // R2

    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mult_load |-> $stable(mult_n) && $stable(mult_m)); // R1

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        core_div >= DIV_MIN && core_div <= DIV_MAX); // R6

    AST_DIV_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(soft_rst) && core_div != $past(core_div) |-> $past(div_tick)); // R7

    AST_CORE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        core_ce |-> pmc_en); // R7

    AST_HOST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        host_ce |=> !host_ce); // R8

    AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> mult_n == DEF_N && mult_m == DEF_M && !host_ce && mult_load); // R9
endmodule

bind clkgen_ctl clkgen_ctl_chk #(.DEF_N(DEF_N), .DEF_M(DEF_M)) chk_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_drop(host_drop),
    .busy(busy), .mult_ready(mult_ready), .mult_load(mult_load),
    .mult_n(mult_n), .mult_m(mult_m), .core_div(core_div),
    .div_tick(div_tick), .core_ce(core_ce), .pmc_en(pmc_en),
    .host_ce(host_ce), .irq(irq)
);

// File: tb/clkgen_ctl_tb.sv
module clkgen_ctl_tb_top;
    localparam logic [4:0]  E_DEF_N   = 5'd0;
    localparam logic [13:0] E_DEF_M   = 14'd121;
    localparam int          E_DEF_DIV = 5;
    localparam int          E_MON     = 16;
    localparam int          NVEC      = 8;
    // {write value, expected divisor, expected core_ce count in 60 cycles}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd2,    8'd2, 8'd30},
        {8'd5,    8'd5, 8'd12},
        {8'd0,    8'd5, 8'd12},
        {8'd7,    8'd5, 8'd12},
        {8'd4,    8'd4, 8'd15},
        {8'd1,    8'd1, 8'd60},
        {8'd3,    8'd3, 8'd20},
        {8'h0A,   8'd3, 8'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_rst = 1'b0, dbg_rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pmc_en = 1'b1, host_cfg_en = 1'b0, mult_ready = 1'b0;
    logic [4:0]  mult_n;
    logic [13:0] mult_m;
    logic        mult_fast, mult_load, core_ce, host_ce, irq;
    logic [2:0]  core_div;

    int total = 0;
    int bad   = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    clkgen_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .dbg_rst(dbg_rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pmc_en(pmc_en), .host_cfg_en(host_cfg_en),
        .mult_ready(mult_ready), .mult_n(mult_n), .mult_m(mult_m),
        .mult_fast(mult_fast), .mult_load(mult_load), .core_div(core_div),
        .core_ce(core_ce), .host_ce(host_ce), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_apply();
        mult_ready = 1'b1;
        cyc(1);
        mult_ready = 1'b0;
    endtask

    task automatic count_core(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (core_ce) c++;
            @(negedge clk);
        end
    endtask

    task automatic count_host(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (host_ce) c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R9 power-on defaults
        chk("R9 n", mult_n, E_DEF_N);
        chk("R9 m", mult_m, E_DEF_M);
        chk("R9 div", core_div, E_DEF_DIV);
        chk("R9 irq", irq, 0);
        chk("R9 load", mult_load, 0);

        // R1 staging writes
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        wr(3'd2, 8'h0B);
        rd(3'd0, rv); chk("R1 mlo", rv, 8'h34);
        rd(3'd1, rv); chk("R1 mhi", rv, 8'h12);
        rd(3'd2, rv); chk("R1 n", rv, 8'h0B);
        chk("R1 cur m held", mult_m, E_DEF_M);
        chk("R1 cur n held", mult_n, E_DEF_N);

        // R2 apply in fast mode
        wr(3'd3, 8'h03);
        chk("R2 load", mult_load, 1);
        chk("R2 m", mult_m, 14'h1234);
        chk("R2 n", mult_n, 5'h0B);
        chk("R2 fast", mult_fast, 1);
        rd(3'd5, rv); chk("R2 busy", rv[0], 1);
        cyc(1);
        chk("R2 load one cycle", mult_load, 0);

        // R5 while busy
        wr(3'd0, 8'h55);
        wr(3'd3, 8'h01);
        chk("R5 start ignored load", mult_load, 0);
        chk("R5 start ignored m", mult_m, 14'h1234);
        // R6 divisor write while busy ignored
        wr(3'd4, 8'd2);
        rd(3'd4, rv); chk("R6 busy write ignored", rv, 1);
        // R3 divisor forced to one
        cyc(6);
        chk("R3 div one", core_div, 1);

        // R4 completion
        finish_apply();
        rd(3'd5, rv);
        chk("R4 busy clear", rv[0], 0);
        chk("R4 done", rv[1], 1);
        chk("R4 irq", irq, 1);
        cyc(3);
        chk("R4 irq sticky", irq, 1);
        wr(3'd5, 8'h02);
        chk("R4 irq cleared", irq, 0);

        // R5 staged value applied by next start
        wr(3'd3, 8'h01);
        chk("R5 m after next start", mult_m, 14'h1255);
        chk("R5 fast normal", mult_fast, 0);
        finish_apply();
        wr(3'd5, 8'h02);

        // R6 R7 divisor vectors
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd4, VEC[v][23:16]);
            rd(3'd4, rv);
            chk("R6 div readback", rv, VEC[v][15:8]);
            cyc(6);
            chk("R7 div in effect", core_div, VEC[v][10:8]);
            count_core(60, c);
            chk("R7 core_ce count", c, VEC[v][7:0]);
        end
        pmc_en = 1'b0;
        count_core(20, c);
        chk("R7 gated off", c, 0);
        pmc_en = 1'b1;

        // R8 R11 host enable and monitor
        host_cfg_en = 1'b1;
        cyc(1);
        rd(3'd5, rv);
        chk("R11 mon busy", rv[2], 1);
        chk("R8 host first low", host_ce, 0);
        cyc(E_MON - 1);
        rd(3'd5, rv);
        chk("R11 mon still busy", rv[3:2], 2'b01);
        cyc(1);
        rd(3'd5, rv);
        chk("R11 mon good", rv[3:2], 2'b10);
        count_host(20, c);
        chk("R8 host half rate", c, 10);

        // R10 host drop fallback
        host_cfg_en = 1'b0;
        cyc(1);
        chk("R10 load", mult_load, 1);
        chk("R10 n", mult_n, E_DEF_N);
        chk("R10 m", mult_m, E_DEF_M);
        chk("R10 host off", host_ce, 0);
        rd(3'd4, rv); chk("R10 div pend", rv, E_DEF_DIV);
        rd(3'd5, rv); chk("R11 cleared on drop", rv[3:0], 4'b0001);
        finish_apply();
        wr(3'd5, 8'h02);

        // R9 soft reset
        host_cfg_en = 1'b1;
        wr(3'd4, 8'd2);
        cyc(6);
        chk("R7 div two", core_div, 2);
        wdt_rst = 1'b1;
        cyc(1);
        wdt_rst = 1'b0;
        chk("R9 soft div", core_div, E_DEF_DIV);
        chk("R9 soft load", mult_load, 1);
        chk("R9 soft m", mult_m, E_DEF_M);
        count_host(10, c);
        chk("R8 host off after soft reset", c, 0);
        finish_apply();
        chk("R4 irq after soft apply", irq, 1);
        dbg_rst = 1'b1;
        cyc(1);
        dbg_rst = 1'b0;
        chk("R9 dbg load", mult_load, 1);
        chk("R9 dbg done cleared", irq, 0);
        finish_apply();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule